// File: doc/BRIEF.md
# Load-Use Hazard and Operand Forwarding Unit

This block sits beside the decode and execute stages of a five-stage in-order integer pipeline. It looks at the source register fields of the instruction in decode and at the load, if there is one, waiting in execute. When the decode instruction needs a value that the load has not yet fetched, it raises a stall. The stall freezes the program counter and the fetch/decode pipeline register, and it replaces the decode controls headed into execute with an all-zero no-op.

The same block also chooses, for each of the two execute-stage operands, where the operand comes from. It can take the value from the register file, from the result held in the memory stage, or from the result held in the writeback stage. When both later stages hold a match, the younger producer in the memory stage wins. The stall and the selects are pure combinational functions of the current pipeline register fields. The clock and reset inputs serve only the embedded checks.

Top module: `luh_hazard_unit`

## Requirements
- R1: `stall` is 1 exactly when `ex_mem_read` and `ex_reg_write` are both 1, `ex_rt` is not register 0, and `ex_rt` equals `id_rs` or `id_rt`.
- R2: `pc_we` is 0 while `stall` is 1 and 1 otherwise, so the same instruction is fetched again.
- R3: `ifid_we` is 0 while `stall` is 1 and 1 otherwise, so the decode instruction stays in place.
- R4: `ex_ctrl_next` is all zeros while `stall` is 1 and equals `id_ctrl` otherwise.
- R5: A forward select equal to 2'b10 picks the memory-stage result. It is produced when `mem_reg_write` is 1 and `mem_rd` equals the operand's source field. The value 2'b11 never appears.
- R6: A forward select equal to 2'b01 picks the writeback-stage result. It is produced when `wb_reg_write` is 1, `wb_rd` equals the source field and the memory stage does not match. 2'b00 means the register file.
- R7: When both the memory and writeback stages write the operand's source register, the select is 2'b10.
- R8: A destination of register 0 never causes a stall or a forward.
- R9: A producer whose register-write control is 0 never causes a stall or a forward.
- R10: Once a hazard stalls and the pipeline advances, so that the bubble enters execute with a zero memory-read control, the stall drops on the next cycle. A load-use hazard therefore costs one bubble.
- R11: `fwd_a` is derived from `ex_rs` and `fwd_b` from `ex_rt`, each on its own.
- R12: A load that has moved on to the memory stage never stalls a consumer. That consumer is served by forwarding instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only by the embedded checks |
| rst | input | 1 | Synchronous active-high reset for the checks |
| id_rs | input | REG_W | First source field of the decode instruction |
| id_rt | input | REG_W | Second source field of the decode instruction |
| id_ctrl | input | CTRL_W | Control bits decoded for the decode instruction |
| ex_mem_read | input | 1 | Execute instruction reads data memory |
| ex_reg_write | input | 1 | Execute instruction writes a register |
| ex_rs | input | REG_W | First source field of the execute instruction |
| ex_rt | input | REG_W | Second source / load target of the execute instruction |
| mem_reg_write | input | 1 | Memory-stage instruction writes a register |
| mem_rd | input | REG_W | Destination of the memory-stage instruction |
| wb_reg_write | input | 1 | Writeback-stage instruction writes a register |
| wb_rd | input | REG_W | Destination of the writeback-stage instruction |
| stall | output | 1 | Load-use hazard detected |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| ex_ctrl_next | output | CTRL_W | Controls passed into the decode/execute register |
| fwd_a | output | 2 | Source select for the first execute operand |
| fwd_b | output | 2 | Source select for the second execute operand |

## Verification
On every cycle the assertions check several properties. The select values stay legal, and register 0 and non-writing producers never forward or stall. The memory stage wins a double match, no stall arises without a load in execute, and a stall always gates both write enables and zeroes the controls. Other behaviour shows only through the bench's scenarios. These include the exact stall condition across mixed field patterns and the single-bubble timing of a load followed by its consumer as the pipeline advances. They also include a load that has moved into the memory stage being served by forwarding rather than a stall.

// File: rtl/luh_pkg.sv
package luh_pkg;
  typedef enum logic [1:0] {
    SRC_REGFILE = 2'b00,
    SRC_WB      = 2'b01,
    SRC_MEM     = 2'b10
  } opnd_src_e;
endpackage

// File: rtl/luh_load_use.sv
module luh_load_use #(
  parameter int REG_W = 5
) (
  input  logic             ld_valid,
  input  logic             ld_writes,
  input  logic [REG_W-1:0] ld_dst,
  input  logic [REG_W-1:0] use_a,
  input  logic [REG_W-1:0] use_b,
  output logic             hazard
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;
  logic dst_live;
  always_comb begin
    dst_live = ld_valid && ld_writes && (ld_dst != ZERO_REG);
    hazard   = dst_live && ((ld_dst == use_a) || (ld_dst == use_b));
  end
endmodule

// File: rtl/luh_fwd_pick.sv
module luh_fwd_pick
  import luh_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] src,
  input  logic             mem_we,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             wb_we,
  input  logic [REG_W-1:0] wb_dst,
  output logic [1:0]       sel
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;
  logic mem_hit, wb_hit;
  opnd_src_e pick;

  always_comb begin
    mem_hit = mem_we && (mem_dst != ZERO_REG) && (mem_dst == src);
    wb_hit  = wb_we  && (wb_dst  != ZERO_REG) && (wb_dst  == src);
    if (mem_hit)     pick = SRC_MEM;
    else if (wb_hit) pick = SRC_WB;
    else             pick = SRC_REGFILE;
    sel = pick;
  end

  // R5: the unused code never leaves this selector
  assert_sel_legal_R5: assert property (@(posedge clk) disable iff (rst)
    sel != 2'b11);
  // R8: register 0 is never a forwarding source
  assert_zero_reg_R8: assert property (@(posedge clk) disable iff (rst)
    (src == ZERO_REG) |-> (sel == 2'b00));
  // R9: silent producers never forward
  assert_no_write_R9: assert property (@(posedge clk) disable iff (rst)
    (!mem_we && !wb_we) |-> (sel == 2'b00));
  // R7: memory stage wins a double match
  assert_mem_first_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_we && wb_we && mem_dst == src && wb_dst == src && src != ZERO_REG)
      |-> (sel == 2'b10));
endmodule

// File: rtl/luh_bubble_gate.sv
module luh_bubble_gate #(
  parameter int CTRL_W = 9
) (
  input  logic              squash,
  input  logic [CTRL_W-1:0] ctrl_in,
  output logic [CTRL_W-1:0] ctrl_out
);
  always_comb begin
    ctrl_out = squash ? '0 : ctrl_in;
  end
endmodule

// File: rtl/luh_hazard_unit.sv
module luh_hazard_unit #(
  parameter int REG_W  = 5,
  parameter int CTRL_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_W-1:0]  id_rs,
  input  logic [REG_W-1:0]  id_rt,
  input  logic [CTRL_W-1:0] id_ctrl,
  input  logic              ex_mem_read,
  input  logic              ex_reg_write,
  input  logic [REG_W-1:0]  ex_rs,
  input  logic [REG_W-1:0]  ex_rt,
  input  logic              mem_reg_write,
  input  logic [REG_W-1:0]  mem_rd,
  input  logic              wb_reg_write,
  input  logic [REG_W-1:0]  wb_rd,
  output logic              stall,
  output logic              pc_we,
  output logic              ifid_we,
  output logic [CTRL_W-1:0] ex_ctrl_next,
  output logic [1:0]        fwd_a,
  output logic [1:0]        fwd_b
);
  localparam int NUM_OPND = 2;

  logic             hz;
  logic [REG_W-1:0] opnd_src [NUM_OPND];
  logic [1:0]       opnd_sel [NUM_OPND];

  luh_load_use #(.REG_W(REG_W)) u_detect (
    .ld_valid (ex_mem_read),
    .ld_writes(ex_reg_write),
    .ld_dst   (ex_rt),
    .use_a    (id_rs),
    .use_b    (id_rt),
    .hazard   (hz)
  );

  always_comb begin
    stall   = hz;
    pc_we   = ~hz;
    ifid_we = ~hz;
  end

  luh_bubble_gate #(.CTRL_W(CTRL_W)) u_bubble (
    .squash  (hz),
    .ctrl_in (id_ctrl),
    .ctrl_out(ex_ctrl_next)
  );

  assign opnd_src[0] = ex_rs;
  assign opnd_src[1] = ex_rt;

  for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
    luh_fwd_pick #(.REG_W(REG_W)) u_pick (
      .clk    (clk),
      .rst    (rst),
      .src    (opnd_src[g]),
      .mem_we (mem_reg_write),
      .mem_dst(mem_rd),
      .wb_we  (wb_reg_write),
      .wb_dst (wb_rd),
      .sel    (opnd_sel[g])
    );
  end

  assign fwd_a = opnd_sel[0];
  assign fwd_b = opnd_sel[1];

  // R1: no load in execute, no stall
  assert_need_load_R1: assert property (@(posedge clk) disable iff (rst)
    !ex_mem_read |-> !stall);
  // R8: a load into register 0 never stalls
  assert_zero_dst_R8: assert property (@(posedge clk) disable iff (rst)
    (ex_rt == '0) |-> !stall);
  // R2 / R3: a stall freezes both write enables
  assert_freeze_R2: assert property (@(posedge clk) disable iff (rst)
    stall |-> (!pc_we && !ifid_we));
  // R4: a stall sends only zero controls into execute
  assert_bubble_R4: assert property (@(posedge clk) disable iff (rst)
    stall |-> (ex_ctrl_next == '0));
endmodule

// File: tb/test_luh_hazard_unit.sv
module test_luh_hazard_unit;
  localparam int REG_W  = 5;
  localparam int CTRL_W = 9;
  localparam int CLK_PERIOD = 10;

  logic clk = 0;
  logic rst = 1;
  logic [REG_W-1:0]  id_rs = 0, id_rt = 0, ex_rs = 0, ex_rt = 0, mem_rd = 0, wb_rd = 0;
  logic [CTRL_W-1:0] id_ctrl = 0;
  logic ex_mem_read = 0, ex_reg_write = 0, mem_reg_write = 0, wb_reg_write = 0;
  logic stall, pc_we, ifid_we;
  logic [CTRL_W-1:0] ex_ctrl_next;
  logic [1:0] fwd_a, fwd_b;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  luh_hazard_unit #(.REG_W(REG_W), .CTRL_W(CTRL_W)) i_luh_hazard_unit (
    .clk(clk), .rst(rst), .id_rs(id_rs), .id_rt(id_rt), .id_ctrl(id_ctrl),
    .ex_mem_read(ex_mem_read), .ex_reg_write(ex_reg_write), .ex_rs(ex_rs), .ex_rt(ex_rt),
    .mem_reg_write(mem_reg_write), .mem_rd(mem_rd), .wb_reg_write(wb_reg_write), .wb_rd(wb_rd),
    .stall(stall), .pc_we(pc_we), .ifid_we(ifid_we), .ex_ctrl_next(ex_ctrl_next),
    .fwd_a(fwd_a), .fwd_b(fwd_b));

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int ref_src(input int s);
    if (s != 0 && mem_reg_write && mem_rd == s) return 2;
    if (s != 0 && wb_reg_write && wb_rd == s) return 1;
    return 0;
  endfunction

  // Reference model, compared on every clock at the falling edge
  task automatic compare_all(input string ctx);
    int exp_stall;
    exp_stall = (ex_mem_read && ex_reg_write && ex_rt != 0 &&
                 (ex_rt == id_rs || ex_rt == id_rt)) ? 1 : 0;
    check({"R1 stall ", ctx}, stall, exp_stall);
    check({"R2 pc_we ", ctx}, pc_we, 1 - exp_stall);
    check({"R3 ifid_we ", ctx}, ifid_we, 1 - exp_stall);
    check({"R4 ctrl ", ctx}, ex_ctrl_next, exp_stall ? 0 : id_ctrl);
    check({"R11 fwd_a ", ctx}, fwd_a, ref_src(ex_rs));
    check({"R11 fwd_b ", ctx}, fwd_b, ref_src(ex_rt));
  endtask

  task automatic clear_all();
    id_rs = 0; id_rt = 0; id_ctrl = 0; ex_mem_read = 0; ex_reg_write = 0;
    ex_rs = 0; ex_rt = 0; mem_reg_write = 0; mem_rd = 0; wb_reg_write = 0; wb_rd = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    // reset state with idle pipeline
    check("R2 reset pc_we", pc_we, 1);
    check("R1 reset stall", stall, 0);
    check("R5 reset fwd_a", fwd_a, 0);
    @(posedge clk); rst = 0;

    // R1: load r5 in execute, decode reads r5 as its second source
    @(posedge clk); #1;
    ex_mem_read = 1; ex_reg_write = 1; ex_rt = 5; id_rs = 2; id_rt = 5; id_ctrl = 9'h1a5;
    @(negedge clk); compare_all("rt match");
    check("R1 stall on rt", stall, 1);
    check("R4 bubble zero", ex_ctrl_next, 0);

    // R10: advance - bubble enters execute, load moves to memory stage
    @(posedge clk); #1;
    ex_mem_read = 0; ex_reg_write = 0; ex_rt = 0; ex_rs = 0;
    mem_reg_write = 1; mem_rd = 5;
    @(negedge clk); compare_all("after bubble");
    check("R10 stall dropped", stall, 0);
    // consumer then enters execute with load now in writeback
    @(posedge clk); #1;
    ex_rs = 2; ex_rt = 5; mem_reg_write = 0; mem_rd = 0; wb_reg_write = 1; wb_rd = 5;
    @(negedge clk); compare_all("consumer exec");
    check("R6 fwd_b from wb", fwd_b, 1);

    // R12: load in memory stage, consumer in decode adjacent-but-one: no stall
    @(posedge clk); #1; clear_all();
    mem_reg_write = 1; mem_rd = 7; id_rs = 7; ex_rs = 7; id_ctrl = 9'h0ff;
    @(negedge clk); compare_all("R12");
    check("R12 no stall", stall, 0);
    check("R5 fwd_a from mem", fwd_a, 2);

    // R7: both stages write r3
    @(posedge clk); #1; clear_all();
    mem_reg_write = 1; mem_rd = 3; wb_reg_write = 1; wb_rd = 3; ex_rs = 3; ex_rt = 3;
    @(negedge clk); compare_all("R7");
    check("R7 priority a", fwd_a, 2);
    check("R7 priority b", fwd_b, 2);

    // R8: register 0 everywhere
    @(posedge clk); #1; clear_all();
    ex_mem_read = 1; ex_reg_write = 1; ex_rt = 0; id_rs = 0;
    mem_reg_write = 1; mem_rd = 0; wb_reg_write = 1; wb_rd = 0; id_ctrl = 9'h155;
    @(negedge clk); compare_all("R8");
    check("R8 no stall r0", stall, 0);
    check("R8 no fwd r0", fwd_b, 0);

    // R9: matching fields but write controls off
    @(posedge clk); #1; clear_all();
    ex_mem_read = 1; ex_reg_write = 0; ex_rt = 4; id_rs = 4;
    mem_rd = 6; wb_rd = 6; ex_rs = 6;
    @(negedge clk); compare_all("R9");
    check("R9 no stall", stall, 0);
    check("R9 no fwd", fwd_a, 0);

    // R1: match on decode first source, and a non-load producer in execute
    @(posedge clk); #1; clear_all();
    ex_mem_read = 1; ex_reg_write = 1; ex_rt = 9; id_rs = 9; id_rt = 1;
    @(negedge clk); check("R1 stall on rs", stall, 1);
    @(posedge clk); #1; ex_mem_read = 0;
    @(negedge clk); check("R1 no stall alu op", stall, 0);

    // Mixed patterns from a small register set to force collisions
    for (int i = 0; i < 400; i++) begin
      @(posedge clk); #1;
      id_rs = REG_W'($urandom_range(0, 3)); id_rt = REG_W'($urandom_range(0, 3));
      ex_rs = REG_W'($urandom_range(0, 3)); ex_rt = REG_W'($urandom_range(0, 3));
      mem_rd = REG_W'($urandom_range(0, 3)); wb_rd = REG_W'($urandom_range(0, 3));
      ex_mem_read = 1'($urandom_range(0, 1)); ex_reg_write = 1'($urandom_range(0, 1));
      mem_reg_write = 1'($urandom_range(0, 1)); wb_reg_write = 1'($urandom_range(0, 1));
      id_ctrl = CTRL_W'($urandom);
      @(negedge clk); compare_all("mixed");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule